// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a receive clock-recovery loop should follow the incoming data or fall back to the local reference. It counts two single-cycle enable pulse streams, one from the reference clock and one from the recovered clock, over a window of 2^WIN_LOG2 reference pulses. When the window closes it takes the absolute difference between the recovered count and the window length. That difference is the frequency offset in counts. At the default window of 16384 pulses, one count is about 61 ppm.

The lock flag is updated only when a window closes. The thresholds it uses depend on its present value. A locked detector tolerates a larger offset than an unlocked one needs in order to acquire. Between each pair of thresholds there is a band where the flag is held. A gating input carries the result of an external run-length check. When that input is low, the flag is forced to unlocked and the detector cannot acquire lock.

Top module: `freq_lock_detect`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears locked to 0 and clears both pulse counters, so the first window after reset spans exactly 2^WIN_LOG2 reference pulses.
- R2: A window closes on the clock edge that samples its 2^WIN_LOG2-th ref_tick. While run_ok is 1, locked changes only on such an edge.
- R3: When locked is 1, a closing window with an offset below LOCK_KEEP (8 counts) leaves locked at 1.
- R4: When locked is 1, a closing window with an offset above LOCK_DROP (12 counts) clears locked to 0.
- R5: When locked is 1, a closing window with an offset from 8 to 12 counts inclusive leaves locked at 1.
- R6: When locked is 0, a closing window with run_ok at 1 and an offset below ACQ_GAIN (4 counts) sets locked to 1.
- R7: When locked is 0, a closing window with an offset above ACQ_REJECT (6 counts) leaves locked at 0.
- R8: When locked is 0, a closing window with an offset from 4 to 6 counts inclusive leaves locked at 0.
- R9: run_ok at 0 at any clock edge makes locked 0 after that edge. This holds at window boundaries too, so lock cannot be acquired while run_ok is low.
- R10: The offset is |N_rec - 2^WIN_LOG2|, where N_rec counts every rec_tick in the window, including one that coincides with the closing ref_tick. A recovered clock that is fast and one that is slow by the same count give the same decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the pulse inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable pulse per reference clock event |
| rec_tick | input | 1 | One-cycle enable pulse per recovered clock event |
| run_ok | input | 1 | Run-length check passed; low forces the unlocked state |
| locked | output | 1 | 1 when the loop should track data, 0 when it should use the reference |

## Verification
The bench sweeps signed offsets from -15 to +15 counts in both lock states. It therefore crosses each threshold edge: 7, 8, 12 and 13 when locked, and 3, 4, 6 and 7 when unlocked. A design with an off-by-one comparison, or one that decides the hold bands instead of keeping the state, flips the flag at exactly one of these points. Negative offsets catch a design that takes a signed rather than an absolute difference, because it would lock on any slow clock. A reset applied partway through a window, and run_ok dropped for one cycle mid-window and for a whole window, catch counters that survive reset and gating that only acts at window ends.

// File: rtl/flk_pkg.sv
// Shared types for the frequency lock detector.
// Assumes nothing beyond IEEE 1800-2017 synthesis support.
package flk_pkg;
    typedef enum logic {
        ST_REFERENCE = 1'b0,
        ST_TRACKING  = 1'b1
    } lock_state_e;
endpackage

// File: rtl/flk_ref_window.sv
// Counts reference pulses and flags the pulse that closes each window of
// 2^WIN_LOG2 pulses. The counter wraps by itself, so every window has
// the same length. Assumes ref_tick is at most one cycle wide per event.
module flk_ref_window #(
    parameter int WIN_LOG2 = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic win_done
);
    logic [WIN_LOG2-1:0] ref_cnt;

    // Closing pulse: the last reference event of the window.
    assign win_done = ref_tick && (&ref_cnt);

    // Advance the reference count; reset restarts the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (ref_tick) begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flk_rec_count.sv
// Counts recovered-clock pulses within the current window. It presents the
// running total, including a pulse in the present cycle, and clears the
// count when the window closes. The count saturates instead of wrapping.
module flk_rec_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_tick,
    input  logic          win_done,
    output logic [CW-1:0] total
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] rec_cnt;

    // Running total with this cycle's pulse folded in, held at full scale.
    always_comb begin
        if (rec_tick && (rec_cnt != CNT_MAX)) begin
            total = rec_cnt + 1'b1;
        end else begin
            total = rec_cnt;
        end
    end

    // Keep the running total; restart it when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n || win_done) begin
            rec_cnt <= '0;
        end else begin
            rec_cnt <= total;
        end
    end
endmodule

// File: rtl/flk_offset.sv
// Computes the absolute distance, in counts, between the recovered total
// and the nominal window length 2^WIN_LOG2. This is pure combinational logic.
module flk_offset #(
    parameter int WIN_LOG2 = 14,
    parameter int CW       = 16
) (
    input  logic [CW-1:0] total,
    output logic [CW-1:0] offset
);
    localparam logic [CW-1:0] NOMINAL = CW'(1) << WIN_LOG2;

    // Subtract in whichever direction keeps the result non-negative.
    always_comb begin
        if (total >= NOMINAL) begin
            offset = total - NOMINAL;
        end else begin
            offset = NOMINAL - total;
        end
    end
endmodule

// File: rtl/flk_lock_fsm.sv
// Two-state lock decision with hysteresis. It is evaluated only when a
// window closes. Each state has its own threshold pair, and an offset that
// falls inside a pair's band keeps the present state. Low run_ok forces
// the reference state in every cycle.
module flk_lock_fsm
    import flk_pkg::*;
#(
    parameter int CW         = 16,
    parameter int LOCK_KEEP  = 8,
    parameter int LOCK_DROP  = 12,
    parameter int ACQ_GAIN   = 4,
    parameter int ACQ_REJECT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_done,
    input  logic          run_ok,
    input  logic [CW-1:0] offset,
    output logic          locked
);
    localparam logic [CW-1:0] KEEP_C   = CW'(LOCK_KEEP);
    localparam logic [CW-1:0] DROP_C   = CW'(LOCK_DROP);
    localparam logic [CW-1:0] GAIN_C   = CW'(ACQ_GAIN);
    localparam logic [CW-1:0] REJECT_C = CW'(ACQ_REJECT);

    lock_state_e state_q;
    lock_state_e state_d;

    // Next state from the present state, the offset and the gate.
    always_comb begin
        state_d = state_q;
        if (win_done) begin
            case (state_q)
                ST_TRACKING: begin
                    if (offset < KEEP_C) begin
                        state_d = ST_TRACKING;
                    end else if (offset > DROP_C) begin
                        state_d = ST_REFERENCE;
                    end
                end
                default: begin
                    if (offset < GAIN_C) begin
                        state_d = ST_TRACKING;
                    end else if (offset > REJECT_C) begin
                        state_d = ST_REFERENCE;
                    end
                end
            endcase
        end
        if (!run_ok) begin
            state_d = ST_REFERENCE;
        end
    end

    // State register; reset selects the reference clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REFERENCE;
        end else begin
            state_q <= state_d;
        end
    end

    assign locked = (state_q == ST_TRACKING);
endmodule

// File: rtl/freq_lock_detect.sv
// Top level of the frequency lock detector. It measures the recovered pulse
// count over a window of 2^WIN_LOG2 reference pulses and updates a
// hysteretic lock flag at each window end. Assumes both pulse streams are
// synchronous to clk and never more than one cycle wide per event.
module freq_lock_detect #(
    parameter int WIN_LOG2   = 14,
    parameter int LOCK_KEEP  = 8,
    parameter int LOCK_DROP  = 12,
    parameter int ACQ_GAIN   = 4,
    parameter int ACQ_REJECT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic rec_tick,
    input  logic run_ok,
    output logic locked
);
    localparam int CW = WIN_LOG2 + 2;

    logic          win_done;
    logic [CW-1:0] rec_total;
    logic [CW-1:0] offset;

    flk_ref_window #(.WIN_LOG2(WIN_LOG2)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .win_done (win_done)
    );

    flk_rec_count #(.CW(CW)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_tick (rec_tick),
        .win_done (win_done),
        .total    (rec_total)
    );

    flk_offset #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_offset (
        .total  (rec_total),
        .offset (offset)
    );

    flk_lock_fsm #(
        .CW         (CW),
        .LOCK_KEEP  (LOCK_KEEP),
        .LOCK_DROP  (LOCK_DROP),
        .ACQ_GAIN   (ACQ_GAIN),
        .ACQ_REJECT (ACQ_REJECT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_done (win_done),
        .run_ok   (run_ok),
        .offset   (offset),
        .locked   (locked)
    );
endmodule

// File: rtl/freq_lock_detect_chk.sv
// Property checker for freq_lock_detect. It is bound to every instance and
// observes the window strobe and the offset that separate submodules drive.
module freq_lock_detect_chk #(
    parameter int CW         = 16,
    parameter int LOCK_KEEP  = 8,
    parameter int LOCK_DROP  = 12,
    parameter int ACQ_GAIN   = 4,
    parameter int ACQ_REJECT = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_ok,
    input logic          win_done,
    input logic [CW-1:0] offset,
    input logic          locked
);
    assert_gate_forces_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !locked);

    assert_flag_steady_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && !win_done) |=> $stable(locked));

    assert_keep_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && run_ok && locked && (offset < CW'(LOCK_KEEP))) |=> locked);

    assert_drop_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && locked && (offset > CW'(LOCK_DROP))) |=> !locked);

    assert_acquire_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && run_ok && !locked && (offset < CW'(ACQ_GAIN))) |=> locked);

    assert_stay_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !locked && (offset > CW'(ACQ_REJECT))) |=> !locked);
endmodule

bind freq_lock_detect freq_lock_detect_chk #(
    .CW         (CW),
    .LOCK_KEEP  (LOCK_KEEP),
    .LOCK_DROP  (LOCK_DROP),
    .ACQ_GAIN   (ACQ_GAIN),
    .ACQ_REJECT (ACQ_REJECT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_ok   (run_ok),
    .win_done (win_done),
    .offset   (offset),
    .locked   (locked)
);

// File: tb/sim_freq_lock_detect.sv
// Sweeps signed count offsets in both lock states on a short window and
// compares the flag against an arithmetic model of the requirements.
module sim_freq_lock_detect;
    localparam int WL  = 6;
    localparam int WIN = 1 << WL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic rec_tick = 1'b0;
    logic run_ok = 1'b1;
    logic locked;

    int n_tests = 0;
    int n_fail = 0;
    bit model = 1'b0;

    always #10 clk = ~clk;

    freq_lock_detect #(.WIN_LOG2(WL)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .rec_tick (rec_tick),
        .run_ok   (run_ok),
        .locked   (locked)
    );

    task automatic check(input string req, input bit exp, input string what);
        n_tests++;
        if (locked !== exp) begin
            n_fail++;
            $display("FAIL %s %s: locked=%0b expected=%0b", req, what, locked, exp);
        end
    endtask

    function automatic bit decide(input bit cur, input int d, input bit ok);
        int a;
        a = (d < 0) ? -d : d;
        if (!ok) return 1'b0;
        if (cur) return (a > 12) ? 1'b0 : 1'b1;
        return (a < 4) ? 1'b1 : 1'b0;
    endfunction

    // One window: 2*WIN cycles, a ref pulse on odd cycles, WIN+d rec pulses.
    task automatic run_window(input int d, input bit ok);
        for (int i = 0; i < 2 * WIN; i++) begin
            @(negedge clk);
            ref_tick = i[0];
            rec_tick = (i < WIN + d);
            run_ok   = ok;
        end
        @(negedge clk);
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        run_ok   = 1'b1;
        model = decide(model, d, ok);
    endtask

    function automatic string req_of(input bit cur, input int d);
        int a;
        a = (d < 0) ? -d : d;
        if (cur) return (a < 8) ? "R3" : (a > 12) ? "R4" : "R5";
        return (a < 4) ? "R6" : (a > 6) ? "R7" : "R8";
    endfunction

    initial begin : watchdog
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1", 1'b0, "flag after reset");
        rst_n = 1'b1;

        // R1: a partial window followed by reset must not shorten the next one.
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            ref_tick = i[0];
            rec_tick = 1'b1;
        end
        @(negedge clk);
        rst_n = 1'b0;
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = 1'b0;
        run_window(0, 1'b1);
        check("R1", model, "first window after mid-window reset");

        // R3..R8 and R10: sweep signed offsets from both starting states.
        for (int st = 0; st < 2; st++) begin
            for (int d = -15; d <= 15; d++) begin
                run_window(st == 1 ? 0 : 20, 1'b1);
                check(st == 1 ? "R6" : "R4", bit'(st), "preset state");
                run_window(d, 1'b1);
                check(req_of(bit'(st), d), model,
                      $sformatf("R10 offset %0d from state %0d", d, st));
            end
        end

        // R2: the flag holds mid-window even when that window will drop lock.
        run_window(0, 1'b1);
        for (int i = 0; i < 2 * WIN; i++) begin
            @(negedge clk);
            if (i == WIN) check("R2", 1'b1, "mid-window flag steady");
            ref_tick = i[0];
            rec_tick = (i < WIN + 20);
        end
        @(negedge clk);
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        model = 1'b0;
        check("R2", 1'b0, "drop at window end");

        // R9: a one-cycle gate mid-window unlocks at once.
        run_window(0, 1'b1);
        check("R9", 1'b1, "locked before gate");
        for (int i = 0; i < 2 * WIN; i++) begin
            @(negedge clk);
            if (i == 11) check("R9", 1'b0, "one cycle after gate");
            ref_tick = i[0];
            rec_tick = (i < WIN);
            run_ok = (i != 10);
        end
        @(negedge clk);
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        run_ok = 1'b1;
        model = 1'b1;
        check("R9", 1'b1, "reacquire after gate released");

        // R9: a whole window with the gate low cannot acquire lock.
        run_window(25, 1'b1);
        run_window(0, 1'b0);
        check("R9", 1'b0, "no acquire while gated");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule